// File: doc/BRIEF.md
# Tagged Word Memory for Producer-Consumer Handoff

This block is a small word-addressed storage array in which every word carries a one-bit occupancy tag that says whether the word currently holds unconsumed data. A producer port deposits a word with a synchronizing write. That write succeeds only when the word is vacant, and it marks the word occupied. A consumer port takes a word with a synchronizing read. That read succeeds only when the word is occupied, and it marks the word vacant. Each tag changes in the same clock edge as the data access it guards, so no other request can come between the check and the update.

A request that is not allowed is not queued. It completes with a retry response and changes nothing, and the requester issues it again later. Each port can also issue plain accesses that skip the tag check and leave the tag as it is. These are meant for initialisation, debug inspection and data that needs no handoff. A plain read reports the word's tag next to its data, so software can see the occupancy state without changing it.

Both ports take one request per cycle and answer exactly one cycle later. When both ports name the same word in the same cycle, the write is applied first and the read acts on the result.

Top module: `fe_mem`

## Requirements
- R1: After reset every tag is vacant. A synchronizing read of any word then completes with retry, and both response valids are low until a request is made.
- R2: A synchronizing write to a vacant word stores the data, sets the tag to occupied and completes with done (valid high, retry low).
- R3: A synchronizing write to an occupied word completes with retry. The stored data and the tag are unchanged.
- R4: A synchronizing read of an occupied word returns the data with retry low and the full flag high, then sets the tag to vacant. The stored data is kept.
- R5: A synchronizing read of a vacant word completes with retry, returns all-zero data and the full flag low, and leaves the tag vacant.
- R6: A plain write stores its data whatever the tag is, never retries, and leaves the tag unchanged.
- R7: A plain read never retries. It returns the stored data and, in the full flag, the current tag, and it leaves the tag unchanged.
- R8: When a write and a read address the same word in one cycle, the write takes effect first. The read sees the written data and the tag as the write left it.
- R9: Each port's response appears in the cycle after its request, once per request. No response appears in a cycle that follows no request.
- R10: Tags are per word. An access to one address never changes the tag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present this cycle |
| wr_sync | input | 1 | 1 = synchronizing write, 0 = plain write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request present this cycle |
| rd_sync | input | 1 | 1 = synchronizing read, 0 = plain read |
| rd_addr | input | ADDR_W | Read word address |
| wr_rsp_valid | output | 1 | Write response for the previous cycle's request |
| wr_rsp_retry | output | 1 | Write was refused; nothing changed |
| rd_rsp_valid | output | 1 | Read response for the previous cycle's request |
| rd_rsp_retry | output | 1 | Read was refused; nothing changed |
| rd_rsp_data | output | DATA_W | Read data, zero when retried |
| rd_rsp_full | output | 1 | Tag of the word as the read saw it |

## Verification
A tag stuck at occupied or at vacant shows up at the ports on the next synchronizing access to that word: a retry appears where done was expected, or the reverse, one cycle after the request. A tag cleared or set by mistake, for example by a plain access or a neighbouring address, shows up on the next plain read of that word as a wrong full flag. A wrong write-before-read order on a shared address shows up at once in the same-cycle read response, as stale data or a refused consume.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

   typedef enum logic [1:0] {
      RSP_IDLE  = 2'd0,
      RSP_DONE  = 2'd1,
      RSP_RETRY = 2'd2
   } rsp_kind_e;

   function automatic rsp_kind_e rsp_of(input logic req, input logic accepted);
      if (!req)          return RSP_IDLE;
      else if (accepted) return RSP_DONE;
      else               return RSP_RETRY;
   endfunction

endpackage

// File: rtl/fe_tag_bank.sv
module fe_tag_bank #(
   parameter int DEPTH = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_idx,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_idx,
   input  logic [ADDR_W-1:0] look_a_idx,
   output logic              look_a,
   input  logic [ADDR_W-1:0] look_b_idx,
   output logic              look_b
);

   logic [DEPTH-1:0] tags_q;

   // set applied before clear: a same-word produce+consume leaves it vacant
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tags_q <= '0;
      end else begin
         if (set_en) tags_q[set_idx] <= 1'b1;
         if (clr_en) tags_q[clr_idx] <= 1'b0;
      end
   end

   assign look_a = tags_q[look_a_idx];
   assign look_b = tags_q[look_b_idx];

endmodule

// File: rtl/fe_word_bank.sv
module fe_word_bank #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 16,
   parameter bit RESET_WORDS = 1'b1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] words_q [DEPTH];

   generate
      if (RESET_WORDS) begin : g_rst_words
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
            end else if (we) begin
               words_q[waddr] <= wdata;
            end
         end
      end else begin : g_plain_words
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we) words_q[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = words_q[raddr];

endmodule

// File: rtl/fe_gate.sv
module fe_gate #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              wr_valid,
   input  logic              wr_sync,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic              rd_sync,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              tag_at_wr,
   input  logic              tag_at_rd,
   input  logic [DATA_W-1:0] word_at_rd,
   output logic              wr_accept,
   output logic              rd_accept,
   output logic              rd_seen_full,
   output logic [DATA_W-1:0] rd_word,
   output logic              tag_set,
   output logic              tag_clr
);

   logic same_word;

   always_comb begin
      same_word = (wr_addr == rd_addr);
      wr_accept = wr_valid && (!wr_sync || !tag_at_wr);
      // the write is ordered ahead of a read of the same word
      if (wr_accept && same_word) begin
         rd_seen_full = wr_sync ? 1'b1 : tag_at_rd;
         rd_word      = wr_data;
      end else begin
         rd_seen_full = tag_at_rd;
         rd_word      = word_at_rd;
      end
      rd_accept = rd_valid && (!rd_sync || rd_seen_full);
      tag_set   = wr_accept && wr_sync;
      tag_clr   = rd_accept && rd_sync;
   end

endmodule

// File: rtl/fe_mem.sv
module fe_mem #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 16,
   parameter bit RESET_WORDS = 1'b1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_sync,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic              rd_sync,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              wr_rsp_valid,
   output logic              wr_rsp_retry,
   output logic              rd_rsp_valid,
   output logic              rd_rsp_retry,
   output logic [DATA_W-1:0] rd_rsp_data,
   output logic              rd_rsp_full
);
   import fe_mem_pkg::*;

   generate
      if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("fe_mem: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fe_mem: DATA_W must be positive");
      end
   endgenerate

   logic              tag_at_wr, tag_at_rd;
   logic [DATA_W-1:0] word_at_rd, rd_word;
   logic              wr_accept, rd_accept, rd_seen_full;
   logic              tag_set, tag_clr;

   fe_tag_bank #(.DEPTH(DEPTH)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (tag_set),
      .set_idx   (wr_addr),
      .clr_en    (tag_clr),
      .clr_idx   (rd_addr),
      .look_a_idx(wr_addr),
      .look_a    (tag_at_wr),
      .look_b_idx(rd_addr),
      .look_b    (tag_at_rd)
   );

   fe_word_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RESET_WORDS(RESET_WORDS)) u_words (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_accept),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_addr),
      .rdata(word_at_rd)
   );

   fe_gate #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_gate (
      .wr_valid    (wr_valid),
      .wr_sync     (wr_sync),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_valid    (rd_valid),
      .rd_sync     (rd_sync),
      .rd_addr     (rd_addr),
      .tag_at_wr   (tag_at_wr),
      .tag_at_rd   (tag_at_rd),
      .word_at_rd  (word_at_rd),
      .wr_accept   (wr_accept),
      .rd_accept   (rd_accept),
      .rd_seen_full(rd_seen_full),
      .rd_word     (rd_word),
      .tag_set     (tag_set),
      .tag_clr     (tag_clr)
   );

   rsp_kind_e         wr_kind_q, rd_kind_q;
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_kind_q <= RSP_IDLE;
         rd_kind_q <= RSP_IDLE;
         rd_data_q <= '0;
         rd_full_q <= 1'b0;
      end else begin
         wr_kind_q <= rsp_of(wr_valid, wr_accept);
         rd_kind_q <= rsp_of(rd_valid, rd_accept);
         rd_data_q <= rd_accept ? rd_word : '0;
         rd_full_q <= rd_valid && rd_seen_full;
      end
   end

   assign wr_rsp_valid = (wr_kind_q != RSP_IDLE);
   assign wr_rsp_retry = (wr_kind_q == RSP_RETRY);
   assign rd_rsp_valid = (rd_kind_q != RSP_IDLE);
   assign rd_rsp_retry = (rd_kind_q == RSP_RETRY);
   assign rd_rsp_data  = rd_data_q;
   assign rd_rsp_full  = rd_full_q;

endmodule

// File: rtl/fe_mem_chk.sv
module fe_mem_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_sync,
   input logic              rd_valid,
   input logic              rd_sync,
   input logic              wr_rsp_valid,
   input logic              wr_rsp_retry,
   input logic              rd_rsp_valid,
   input logic              rd_rsp_retry,
   input logic [DATA_W-1:0] rd_rsp_data,
   input logic              rd_rsp_full
);

   p_wr_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> wr_rsp_valid);
   p_wr_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> !wr_rsp_valid);
   p_rd_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_rsp_valid);
   p_rd_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !rd_rsp_valid);
   p_plain_wr_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_sync) |=> !wr_rsp_retry);
   p_plain_rd_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_sync) |=> !rd_rsp_retry);
   p_sync_rd_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_sync) |=> (rd_rsp_retry == !rd_rsp_full));
   p_retry_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rsp_retry |-> (rd_rsp_data == '0));

endmodule

bind fe_mem fe_mem_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .wr_sync     (wr_sync),
   .rd_valid    (rd_valid),
   .rd_sync     (rd_sync),
   .wr_rsp_valid(wr_rsp_valid),
   .wr_rsp_retry(wr_rsp_retry),
   .rd_rsp_valid(rd_rsp_valid),
   .rd_rsp_retry(rd_rsp_retry),
   .rd_rsp_data (rd_rsp_data),
   .rd_rsp_full (rd_rsp_full)
);

// File: tb/fe_mem_test.sv
`timescale 1ns/1ps
module fe_mem_test;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_valid = 1'b0, wr_sync = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_valid = 1'b0, rd_sync = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              wr_rsp_valid, wr_rsp_retry, rd_rsp_valid, rd_rsp_retry, rd_rsp_full;
   logic [DATA_W-1:0] rd_rsp_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   fe_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_sync(wr_sync), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_sync(rd_sync), .rd_addr(rd_addr),
      .wr_rsp_valid(wr_rsp_valid), .wr_rsp_retry(wr_rsp_retry),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_retry(rd_rsp_retry),
      .rd_rsp_data(rd_rsp_data), .rd_rsp_full(rd_rsp_full)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive one cycle of requests (at negedge), return after response is visible
   task automatic step(input logic wv, input logic ws, input int wa, input int wd,
                       input logic rv, input logic rs, input int ra);
      wr_valid = wv; wr_sync = ws; wr_addr = ADDR_W'(wa); wr_data = DATA_W'(wd);
      rd_valid = rv; rd_sync = rs; rd_addr = ADDR_W'(ra);
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0; rd_valid = 1'b0;
   endtask

   task automatic wr_op(input string req, input logic ws, input int a, input int d, input logic exp_retry);
      step(1'b1, ws, a, d, 1'b0, 1'b0, 0);
      check(req, "wr valid", int'(wr_rsp_valid), 1);
      check(req, "wr retry", int'(wr_rsp_retry), int'(exp_retry));
   endtask

   task automatic rd_op(input string req, input logic rs, input int a,
                        input logic exp_retry, input int exp_data, input logic exp_full);
      step(1'b0, 1'b0, 0, 0, 1'b1, rs, a);
      check(req, "rd valid", int'(rd_rsp_valid), 1);
      check(req, "rd retry", int'(rd_rsp_retry), int'(exp_retry));
      check(req, "rd data", int'(rd_rsp_data), exp_data);
      check(req, "rd full", int'(rd_rsp_full), int'(exp_full));
   endtask

   task automatic t_reset();
      check("R1", "wr valid at reset", int'(wr_rsp_valid), 0);
      check("R1", "rd valid at reset", int'(rd_rsp_valid), 0);
      for (int a = 0; a < DEPTH; a++) rd_op("R1", 1'b1, a, 1'b1, 0, 1'b0);
   endtask

   task automatic t_produce();
      wr_op("R2", 1'b1, 3, 16'hA5A5, 1'b0);
      rd_op("R2", 1'b0, 3, 1'b0, 16'hA5A5, 1'b1);
   endtask

   task automatic t_produce_full();
      wr_op("R3", 1'b1, 3, 16'h1111, 1'b1);
      rd_op("R3", 1'b0, 3, 1'b0, 16'hA5A5, 1'b1);
   endtask

   task automatic t_consume();
      rd_op("R4", 1'b1, 3, 1'b0, 16'hA5A5, 1'b1);
      rd_op("R4", 1'b0, 3, 1'b0, 16'hA5A5, 1'b0);
   endtask

   task automatic t_consume_empty();
      rd_op("R5", 1'b1, 3, 1'b1, 0, 1'b0);
      wr_op("R5", 1'b1, 3, 16'h2222, 1'b0);
      rd_op("R5", 1'b1, 3, 1'b0, 16'h2222, 1'b1);
   endtask

   task automatic t_plain_write();
      wr_op("R6", 1'b0, 5, 16'h0505, 1'b0);
      rd_op("R6", 1'b0, 5, 1'b0, 16'h0505, 1'b0);
      wr_op("R6", 1'b1, 5, 16'h0555, 1'b0);
      wr_op("R6", 1'b0, 5, 16'h0606, 1'b0);
      rd_op("R6", 1'b0, 5, 1'b0, 16'h0606, 1'b1);
   endtask

   task automatic t_plain_read();
      rd_op("R7", 1'b0, 5, 1'b0, 16'h0606, 1'b1);
      rd_op("R7", 1'b0, 5, 1'b0, 16'h0606, 1'b1);
      rd_op("R7", 1'b1, 5, 1'b0, 16'h0606, 1'b1);
      rd_op("R7", 1'b0, 5, 1'b0, 16'h0606, 1'b0);
   endtask

   task automatic t_same_cycle();
      // vacant word: produce and consume together both succeed
      step(1'b1, 1'b1, 7, 16'h7777, 1'b1, 1'b1, 7);
      check("R8", "wr retry", int'(wr_rsp_retry), 0);
      check("R8", "rd retry", int'(rd_rsp_retry), 0);
      check("R8", "rd data", int'(rd_rsp_data), 16'h7777);
      rd_op("R8", 1'b0, 7, 1'b0, 16'h7777, 1'b0);
      // occupied word: produce refused, consume gets old data
      wr_op("R8", 1'b1, 8, 16'h8888, 1'b0);
      step(1'b1, 1'b1, 8, 16'h9999, 1'b1, 1'b1, 8);
      check("R8", "wr retry full", int'(wr_rsp_retry), 1);
      check("R8", "rd data full", int'(rd_rsp_data), 16'h8888);
      // plain write with sync read on vacant word: read still refused
      step(1'b1, 1'b0, 8, 16'h1234, 1'b1, 1'b1, 8);
      check("R8", "plain wr retry", int'(wr_rsp_retry), 0);
      check("R8", "sync rd after plain wr", int'(rd_rsp_retry), 1);
      rd_op("R8", 1'b0, 8, 1'b0, 16'h1234, 1'b0);
   endtask

   task automatic t_independent();
      wr_op("R10", 1'b1, 0, 16'h0A0A, 1'b0);
      wr_op("R10", 1'b1, DEPTH-1, 16'h0F0F, 1'b0);
      rd_op("R10", 1'b1, 1, 1'b1, 0, 1'b0);
      rd_op("R10", 1'b1, DEPTH-2, 1'b1, 0, 1'b0);
      rd_op("R10", 1'b1, 0, 1'b0, 16'h0A0A, 1'b1);
      rd_op("R10", 1'b0, DEPTH-1, 1'b0, 16'h0F0F, 1'b1);
   endtask

   task automatic t_timing();
      step(1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 0);
      check("R9", "wr idle", int'(wr_rsp_valid), 0);
      check("R9", "rd idle", int'(rd_rsp_valid), 0);
      step(1'b1, 1'b0, 2, 16'h0202, 1'b0, 1'b0, 0);
      check("R9", "wr only", int'(wr_rsp_valid), 1);
      check("R9", "no rd rsp", int'(rd_rsp_valid), 0);
      @(posedge clk); @(negedge clk);
      check("R9", "single wr rsp", int'(wr_rsp_valid), 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_produce();
      t_produce_full();
      t_consume();
      t_consume_empty();
      t_plain_write();
      t_plain_read();
      t_same_cycle();
      t_independent();
      t_timing();
      finish_run();
   end

endmodule